// File: doc/BRIEF.md
# Instruction Trap Entry Sequencer

This block sits beside an instruction decoder. For each instruction it is offered, it decides whether an instruction exception must be taken and which vector number applies. It receives the fetched 16-bit opcode, the live status word, the address of the next instruction, the supervisor stack pointer, and four run-time condition flags from the datapath.

When an exception is taken, the block first copies the status word. It then forms the new status word, with the supervisor bit set and the trace bit cleared. Next it writes three 16-bit words to the supervisor stack over a simple request/acknowledge word bus. It then reads the two halves of the handler address from the vector table and reports the new program counter with a one-cycle `done` pulse.

Instructions that raise no exception produce no bus traffic.

Top module: `trap_entry_seq`

## Requirements
- R1: An opcode whose bits 15..12 are 4'b1010 selects vector 10, ahead of every other cause.
- R2: An opcode whose bits 15..12 are 4'b1111 selects vector 11. It is outranked only by R1, which cannot co-occur with it.
- R3: The opcodes 16'h4AFA, 16'h4AFB and 16'h4AFC select vector 4. This takes priority over the causes in R4 and R5.
- R4: An opcode of the form 16'h4E4n selects vector 32+n. It is outranked by R1, R3 and the privilege flag, and it outranks the remaining flags.
- R5: The flags are ranked from highest to lowest as follows. `priv_user` selects vector 8, `div_zero` selects vector 5, `chk_fail` selects vector 6 and `ovf_trap` selects vector 7.
- R6: When `start` is high and no cause is present, nothing happens. The bus stays idle and `busy` stays low. A `start` that arrives while `busy` is high is ignored.
- R7: The stack writes go out in a fixed order. First the low half of `pc_next` is written to `sp_in`-2. Next the high half goes to `sp_in`-4. Last, the unmodified `sr_in` goes to `sp_in`-6. `sp_out` equals `sp_in`-6 when `done` is high.
- R8: The stacked PC is the `pc_next` input, which is the address of the instruction that follows the trapping one.
- R9: `sr_new` equals `sr_in` with bit 13 (supervisor) set and bit 15 (trace) cleared. Its value is held from acceptance onward.
- R10: After the stack writes, the block reads address vector×4 and then vector×4+2. `pc_new` is formed as {first word, second word}.
- R11: `done` is high for exactly one cycle, in the cycle after the second vector read is acknowledged. `vec_num` holds the selected vector at that point.
- R12: While `bus_req` is high and `bus_ack` is low, the signals `bus_addr`, `bus_we` and `bus_wdata` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Offers the current instruction for classification |
| opcode | input | 16 | Fetched opcode word |
| sr_in | input | 16 | Live status word |
| pc_next | input | 32 | Address of the following instruction |
| sp_in | input | 32 | Supervisor stack pointer |
| ovf_trap | input | 1 | Overflow-trap instruction with overflow flag set |
| chk_fail | input | 1 | Bounds check failed |
| div_zero | input | 1 | Divide with zero divisor |
| priv_user | input | 1 | Privileged opcode attempted in user mode |
| busy | output | 1 | Entry sequence in progress |
| bus_req | output | 1 | Word transfer request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 32 | Byte address of the word |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Transfer completes this cycle |
| done | output | 1 | New PC loaded (one-cycle pulse) |
| vec_num | output | 8 | Selected vector number |
| sr_new | output | 16 | Status word after entry |
| pc_new | output | 32 | Handler address read from the vector table |
| sp_out | output | 32 | Stack pointer after the three pushes |

## Verification
The bench builds the block with its default bit positions: supervisor at bit 13 and trace at bit 15. The bench's memory model answers the bus after 0, 1 or 2 wait cycles, depending on the test. Those latencies bring the held-request rule within reach, along with back-to-back acknowledges between stack writes and vector reads. Several tests combine causes so that each rank of the priority order is observed. One test raises `start` partway through a sequence.

// File: rtl/trap_entry_seq.sv
module trap_entry_seq #(
  parameter int SUP_BIT = 13,
  parameter int TRC_BIT = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] opcode,
  input  logic [15:0] sr_in,
  input  logic [31:0] pc_next,
  input  logic [31:0] sp_in,
  input  logic        ovf_trap,
  input  logic        chk_fail,
  input  logic        div_zero,
  input  logic        priv_user,
  output logic        busy,
  output logic        bus_req,
  output logic        bus_we,
  output logic [31:0] bus_addr,
  output logic [15:0] bus_wdata,
  input  logic [15:0] bus_rdata,
  input  logic        bus_ack,
  output logic        done,
  output logic [7:0]  vec_num,
  output logic [15:0] sr_new,
  output logic [31:0] pc_new,
  output logic [31:0] sp_out
);

  localparam logic [7:0] V_ILL  = 8'd4;
  localparam logic [7:0] V_DIV  = 8'd5;
  localparam logic [7:0] V_CHK  = 8'd6;
  localparam logic [7:0] V_OVF  = 8'd7;
  localparam logic [7:0] V_PRIV = 8'd8;
  localparam logic [7:0] V_LA   = 8'd10;
  localparam logic [7:0] V_LF   = 8'd11;
  localparam logic [7:0] V_TRAP = 8'd32;

  typedef enum logic [2:0] {S_IDLE, S_PCL, S_PCH, S_SR, S_VHI, S_VLO} st_t;

  st_t         st;
  logic [7:0]  vec_q;
  logic [15:0] sr_save, sr_q, hi_q;
  logic [31:0] pc_q, sp_q, pcn_q;
  logic        done_q;

  logic       line_a, line_f, illeg, is_trap, take;
  logic [7:0] vec_sel;

  assign line_a  = opcode[15:12] == 4'b1010;
  assign line_f  = opcode[15:12] == 4'b1111;
  assign illeg   = (opcode == 16'h4AFA) || (opcode == 16'h4AFB) || (opcode == 16'h4AFC);
  assign is_trap = opcode[15:4] == 12'h4E4;

  always_comb begin
    take    = 1'b1;
    vec_sel = 8'd0;
    if (line_a)         vec_sel = V_LA;
    else if (line_f)    vec_sel = V_LF;
    else if (illeg)     vec_sel = V_ILL;
    else if (priv_user) vec_sel = V_PRIV;
    else if (is_trap)   vec_sel = V_TRAP + {4'd0, opcode[3:0]};
    else if (div_zero)  vec_sel = V_DIV;
    else if (chk_fail)  vec_sel = V_CHK;
    else if (ovf_trap)  vec_sel = V_OVF;
    else                take    = 1'b0;
  end

  assign busy    = st != S_IDLE;
  assign bus_req = busy;
  assign bus_we  = (st == S_PCL) || (st == S_PCH) || (st == S_SR);

  always_comb begin
    case (st)
      S_VHI:   bus_addr = {22'd0, vec_q, 2'b00};
      S_VLO:   bus_addr = {22'd0, vec_q, 2'b10};
      default: bus_addr = sp_q - 32'd2;
    endcase
    case (st)
      S_PCL:   bus_wdata = pc_q[15:0];
      S_PCH:   bus_wdata = pc_q[31:16];
      S_SR:    bus_wdata = sr_save;
      default: bus_wdata = 16'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      vec_q   <= 8'd0;
      sr_save <= 16'd0;
      sr_q    <= 16'd0;
      hi_q    <= 16'd0;
      pc_q    <= 32'd0;
      sp_q    <= 32'd0;
      pcn_q   <= 32'd0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start && take) begin
          vec_q            <= vec_sel;
          sr_save          <= sr_in;
          sr_q             <= sr_in;
          sr_q[SUP_BIT]    <= 1'b1;
          sr_q[TRC_BIT]    <= 1'b0;
          pc_q             <= pc_next;
          sp_q             <= sp_in;
          st               <= S_PCL;
        end
        S_PCL: if (bus_ack) begin sp_q <= sp_q - 32'd2; st <= S_PCH; end
        S_PCH: if (bus_ack) begin sp_q <= sp_q - 32'd2; st <= S_SR;  end
        S_SR:  if (bus_ack) begin sp_q <= sp_q - 32'd2; st <= S_VHI; end
        S_VHI: if (bus_ack) begin hi_q <= bus_rdata; st <= S_VLO; end
        S_VLO: if (bus_ack) begin
          pcn_q  <= {hi_q, bus_rdata};
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign done    = done_q;
  assign vec_num = vec_q;
  assign sr_new  = sr_q;
  assign pc_new  = pcn_q;
  assign sp_out  = sp_q;

endmodule

// File: rtl/trap_entry_seq_chk.sv
module trap_entry_seq_chk #(
  parameter int SUP_BIT = 13,
  parameter int TRC_BIT = 15
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        bus_req,
  input logic        bus_we,
  input logic [31:0] bus_addr,
  input logic [15:0] bus_wdata,
  input logic        bus_ack,
  input logic        done,
  input logic [15:0] sr_new
);

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_req);

  p_sr_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> sr_new[SUP_BIT] && !sr_new[TRC_BIT]);

  p_vec_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_we |-> bus_addr[31:10] == 22'd0 && !bus_addr[0]);

endmodule

bind trap_entry_seq trap_entry_seq_chk #(.SUP_BIT(SUP_BIT), .TRC_BIT(TRC_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .done(done), .sr_new(sr_new)
);

// File: tb/trap_entry_seq_test.sv
module trap_entry_seq_test;
  logic clk = 0, rst_n = 0, start = 0;
  logic [15:0] opcode = 0, sr_in = 0, bus_rdata = 0;
  logic [31:0] pc_next = 0, sp_in = 0;
  logic ovf_trap = 0, chk_fail = 0, div_zero = 0, priv_user = 0, bus_ack = 0;
  logic busy, bus_req, bus_we, done;
  logic [31:0] bus_addr, pc_new, sp_out;
  logic [15:0] bus_wdata, sr_new;
  logic [7:0] vec_num;

  always #2 clk = ~clk;

  trap_entry_seq uut (.*);

  typedef struct packed { logic we; logic [31:0] addr; logic [15:0] data; } xf_t;
  typedef struct packed { logic [7:0] vec; logic [31:0] pc; logic [15:0] sr; logic [31:0] sp; } res_t;
  xf_t  xq[$];
  res_t rq[$];
  int checks = 0, fails = 0, lat = 0, cnt = 0;

  function automatic logic [15:0] vt(input logic [31:0] a);
    return a[15:0] ^ 16'hC35A;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bus_ack = 0;
    if (rst_n && bus_req) begin
      if (cnt >= lat) begin
        xf_t e;
        bus_ack = 1; cnt = 0;
        bus_rdata = vt(bus_addr);
        if (xq.size() == 0) chk("R6 unexpected transfer", {31'd0, bus_we, bus_addr}, 64'd0);
        else begin
          e = xq.pop_front();
          chk(e.we ? "R7 stack write" : "R10 vector read",
              {15'd0, bus_we, bus_addr, (bus_we ? bus_wdata : 16'd0)},
              {15'd0, e.we, e.addr, e.data});
        end
      end else cnt++;
    end
  end

  always @(negedge clk) if (rst_n && done) begin
    res_t r;
    if (rq.size() == 0) chk("R11 unexpected done", 64'd1, 64'd0);
    else begin
      r = rq.pop_front();
      chk("R11 vec_num", {56'd0, vec_num}, {56'd0, r.vec});
      chk("R10 pc_new", {32'd0, pc_new}, {32'd0, r.pc});
      chk("R9 sr_new", {48'd0, sr_new}, {48'd0, r.sr});
      chk("R7 sp_out", {32'd0, sp_out}, {32'd0, r.sp});
    end
  end

  function automatic int ref_vec(input logic [15:0] op, input logic pv, dz, cf, ov);
    if (op[15:12] == 4'hA) return 10;
    if (op[15:12] == 4'hF) return 11;
    if (op == 16'h4AFA || op == 16'h4AFB || op == 16'h4AFC) return 4;
    if (pv) return 8;
    if (op[15:4] == 12'h4E4) return 32 + op[3:0];
    if (dz) return 5;
    if (cf) return 6;
    if (ov) return 7;
    return -1;
  endfunction

  task automatic run(input logic [15:0] op, input logic pv, dz, cf, ov,
                     input logic [15:0] sr, input logic [31:0] pc, sp, input int l, input bit poke);
    int v;
    res_t r;
    lat = l;
    v = ref_vec(op, pv, dz, cf, ov);
    if (v >= 0) begin
      logic [31:0] va;
      va = v * 4;
      xq.push_back({1'b1, sp - 32'd2, pc[15:0]});
      xq.push_back({1'b1, sp - 32'd4, pc[31:16]});
      xq.push_back({1'b1, sp - 32'd6, sr});
      xq.push_back({1'b0, va, 16'd0});
      xq.push_back({1'b0, va + 32'd2, 16'd0});
      r.vec = v[7:0];
      r.pc  = {vt(va), vt(va + 32'd2)};
      r.sr  = (sr | 16'h2000) & ~16'h8000;
      r.sp  = sp - 32'd6;
      rq.push_back(r);
    end
    opcode = op; priv_user = pv; div_zero = dz; chk_fail = cf; ovf_trap = ov;
    sr_in = sr; pc_next = pc; sp_in = sp; start = 1;
    @(negedge clk);
    start = 0; priv_user = 0; div_zero = 0; chk_fail = 0; ovf_trap = 0;
    if (v < 0) begin
      for (int i = 0; i < 4; i++) begin
        chk("R6 idle when no cause", {63'd0, busy | bus_req}, 64'd0);
        @(negedge clk);
      end
    end else begin
      if (poke) begin
        @(negedge clk);
        opcode = 16'hA000; div_zero = 1; start = 1;
        @(negedge clk);
        start = 0; div_zero = 0;
      end
      while (busy) @(negedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    chk("watchdog", 64'd1, 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R6 reset state", {61'd0, busy, bus_req, done}, 64'd0);
    rst_n = 1;
    @(negedge clk);
    run(16'hA123, 1, 1, 0, 0, 16'h8704, 32'h0001_2346, 32'h0000_8000, 0, 0); // R1
    run(16'hF2A0, 1, 0, 1, 0, 16'h0011, 32'h00AB_CDE0, 32'h0000_4000, 1, 0); // R2
    run(16'h4AFA, 1, 0, 0, 0, 16'h0000, 32'h0000_1002, 32'h0000_2000, 2, 0); // R3
    run(16'h4AFB, 0, 0, 0, 0, 16'hA71F, 32'h0000_1004, 32'h0000_2000, 0, 0); // R3
    run(16'h4AFC, 0, 1, 0, 0, 16'h0700, 32'h1234_5678, 32'h0010_0000, 1, 0); // R3
    run(16'h4E4D, 0, 1, 1, 1, 16'h0000, 32'h0000_0400, 32'h0000_3000, 0, 0); // R4
    run(16'h4E40, 0, 0, 0, 0, 16'h8000, 32'h0000_0402, 32'h0000_3000, 2, 0); // R4
    run(16'h4E4F, 1, 0, 0, 0, 16'h0000, 32'h0000_0404, 32'h0000_3000, 1, 0); // R5 priv over TRAP
    run(16'h81C0, 0, 1, 1, 1, 16'h0004, 32'h0000_0406, 32'h0000_5000, 0, 0); // R5 div
    run(16'h4180, 0, 0, 1, 1, 16'h0008, 32'h0000_0408, 32'h0000_5000, 1, 0); // R5 chk
    run(16'h4E76, 0, 0, 0, 1, 16'h0002, 32'h0000_040A, 32'h0000_5000, 2, 0); // R5 ovf
    run(16'h4E71, 0, 0, 0, 0, 16'h2000, 32'h0000_040C, 32'h0000_5000, 0, 0); // R6 none
    run(16'h4E4A, 0, 0, 0, 0, 16'hFFFF, 32'hDEAD_BEEE, 32'h0000_7FFE, 2, 1); // R6 start ignored, R8
    run(16'h0000, 0, 0, 0, 0, 16'h0000, 32'h0000_0000, 32'h0000_0000, 0, 0); // R6 none
    repeat (4) @(negedge clk);
    chk("R11 all results seen", {32'd0, 32'(rq.size())}, 64'd0);
    chk("R7 all transfers seen", {32'd0, 32'(xq.size())}, 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule